// File: doc/BRIEF.md
# Pulse-Width Symbol Transmitter

This block sends bytes and break commands over a single active-low, open-drain serial line. The value of a bit is carried by how long the line is held low at the start of its time slot. A short low pulse means a one and a long low pulse means a zero. After the pulse, the line is released for the rest of the slot. A break is a low period longer than a whole bit time, followed by one bit time with the line released.

The host offers a byte with a valid/ready handshake, or raises a break request while the block is idle. A 2-bit speed selector picks one of four bit times, all derived from a base slot length. The selector is sampled only when a byte or break is accepted.

The block has no drive-high path. The single drive output, when asserted, only pulls the line low. An external pull-up returns the line high.

Top module: `pw_sym_tx`

## Requirements
- R1: The bit time in clock cycles is (2*BASE_CYC) >> speed_sel. Code 0 gives half speed, 1 nominal, 2 double and 3 quadruple speed. BASE_CYC defaults to 64.
- R2: A one bit asserts pull_low for round(0.304 * bit time) cycles at the start of its slot. pull_low is then deasserted for the rest of the slot.
- R3: A zero bit asserts pull_low for round(0.696 * bit time) cycles at the start of its slot. pull_low is then deasserted for the rest of the slot.
- R4: The bits of a byte go out least significant bit first, in back-to-back slots. The first slot starts in the cycle after acceptance.
- R5: in_ready is low from the cycle after a byte is accepted until the final slot has ended.
- R6: done is a single-cycle pulse in the last cycle of the final bit slot of a byte, or in the last cycle of a break. in_ready returns in the next cycle.
- R7: A break asserts pull_low for ceil(1.391 * bit time) cycles. It then deasserts pull_low for exactly one bit time.
- R8: brk_req is accepted only while idle. It is ignored while a byte is in progress. When brk_req and in_valid are both high in an idle cycle, the break wins and in_ready is low in that cycle.
- R9: Changes on speed_sel, in_data and in_valid after acceptance have no effect on the symbols in progress.
- R10: After reset, pull_low and done are low and in_ready is high.
- R11: pull_low is never asserted while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| speed_sel | input | 2 | Bit-time selector, sampled at acceptance |
| in_valid | input | 1 | Byte offered |
| in_data | input | DATA_W | Byte to send, LSB first |
| in_ready | output | 1 | Block can accept a byte |
| brk_req | input | 1 | Request to send a break |
| pull_low | output | 1 | Pull the line low when high; release when low |
| done | output | 1 | Final cycle of a byte or break |

## Verification
The bench follows pull_low cycle by cycle at all four speeds, with random bytes. A design that swapped the one and zero widths, sent the MSB first, or rounded the fractions differently shows up as a wrong pulse length in a named slot. In some runs, speed, data and break inputs are changed in the middle of a byte. A design that did not latch its timing, or that let a break cut in, would bend the remaining slots. The bench also raises a break together with a valid byte. This shows whether the break wins, whether the byte is left untouched, and whether the released tail after the break is exactly one bit time long.

// File: rtl/pw_tx_pkg.sv
package pw_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_BRK  = 2'd2
  } tx_state_e;

  // fractions of a bit time, scaled by 2**FRAC_SH
  localparam int FRAC_SH  = 10;
  localparam int ONE_NUM  = 311;   // ~0.304
  localparam int ZERO_NUM = 713;   // ~0.696
  localparam int BRK_NUM  = 1425;  // ~1.3916

  function automatic int slot_cycles(int base, logic [1:0] sel);
    return (base * 2) >> sel;
  endfunction

  function automatic int frac_near(int len, int num);
    return (len * num + (1 << (FRAC_SH - 1))) >> FRAC_SH;
  endfunction

  function automatic int frac_up(int len, int num);
    return (len * num + (1 << FRAC_SH) - 1) >> FRAC_SH;
  endfunction
endpackage

// File: rtl/pw_tx_timing.sv
module pw_tx_timing #(
  parameter int BASE_CYC = 64,
  parameter int CW       = 10
) (
  input  logic [1:0]    speed_sel,
  output logic [CW-1:0] bit_len,
  output logic [CW-1:0] one_len,
  output logic [CW-1:0] zero_len,
  output logic [CW-1:0] brk_len
);
  import pw_tx_pkg::*;

  int bt;
  always_comb begin
    bt       = slot_cycles(BASE_CYC, speed_sel);
    bit_len  = CW'(bt);
    one_len  = CW'(frac_near(bt, ONE_NUM));
    zero_len = CW'(frac_near(bt, ZERO_NUM));
    brk_len  = CW'(frac_up(bt, BRK_NUM));
  end
endmodule

// File: rtl/pw_tx_slot.sv
module pw_tx_slot #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] low_w,
  input  logic [CW-1:0] slot_len,
  output logic          low_now,
  output logic          slot_end
);
  logic [CW-1:0] cnt_q;

  assign low_now  = run && (cnt_q < low_w);
  assign slot_end = run && (cnt_q == slot_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (slot_end) cnt_q <= '0;
    else if (run)      cnt_q <= cnt_q + 1'b1;
  end

  // R1: the counter stays inside the slot
  a_r1_cnt_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < slot_len));
  // R2: once released, the line stays released until the slot ends
  a_r2_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !low_now && !slot_end) |=> !low_now);
  // R3: every slot opens with a low pulse
  a_r3_slot_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == '0) |-> low_now);
endmodule

// File: rtl/pw_sym_tx.sv
module pw_sym_tx #(
  parameter int BASE_CYC = 64,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed_sel,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              brk_req,
  output logic              pull_low,
  output logic              done
);
  import pw_tx_pkg::*;

  localparam int CW = $clog2(BASE_CYC * 5) + 1;
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [IW-1:0]     idx_q;
  logic [CW-1:0]     bt_q, one_q, zero_q, brk_q;
  logic [CW-1:0]     t_bt, t_one, t_zero, t_brk;

  pw_tx_timing #(.BASE_CYC(BASE_CYC), .CW(CW)) u_timing (
    .speed_sel (speed_sel),
    .bit_len   (t_bt),
    .one_len   (t_one),
    .zero_len  (t_zero),
    .brk_len   (t_brk)
  );

  logic idle, run, accept_byte, accept_brk, low_now, slot_end, last_slot;
  logic [CW-1:0] low_w, slot_len;

  assign idle        = (state_q == ST_IDLE);
  assign run         = !idle;
  assign in_ready    = idle && !brk_req;
  assign accept_byte = in_valid && in_ready;
  assign accept_brk  = idle && brk_req;

  assign low_w    = (state_q == ST_BRK) ? brk_q : (shreg_q[0] ? one_q : zero_q);
  assign slot_len = (state_q == ST_BRK) ? (brk_q + bt_q) : bt_q;

  pw_tx_slot #(.CW(CW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .low_w    (low_w),
    .slot_len (slot_len),
    .low_now  (low_now),
    .slot_end (slot_end)
  );

  assign last_slot = slot_end && ((state_q == ST_BRK) || (idx_q == IW'(DATA_W - 1)));
  assign done      = last_slot;
  assign pull_low  = low_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      bt_q    <= '0;
      one_q   <= '0;
      zero_q  <= '0;
      brk_q   <= '0;
    end else begin
      if (accept_brk || accept_byte) begin
        bt_q   <= t_bt;
        one_q  <= t_one;
        zero_q <= t_zero;
        brk_q  <= t_brk;
        idx_q  <= '0;
      end
      if (accept_brk) begin
        state_q <= ST_BRK;
      end else if (accept_byte) begin
        state_q <= ST_DATA;
        shreg_q <= in_data;
      end else if (last_slot) begin
        state_q <= ST_IDLE;
      end else if (slot_end && state_q == ST_DATA) begin
        shreg_q <= shreg_q >> 1;
        idx_q   <= idx_q + 1'b1;
      end
    end
  end

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: handshake reopens right after the final slot
  a_r5_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (in_ready || brk_req));
  // R11: no pulling while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !pull_low);
  // R9: latched timing stays put while busy
  a_r9_timing_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (idle || $stable(bt_q)));
  // R8: a byte in progress is not displaced
  a_r8_byte_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && !last_slot) |=> (state_q == ST_DATA));
endmodule

// File: tb/test_pw_sym_tx.sv
module test_pw_sym_tx;
  localparam int BASE = 64;
  localparam int DW   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    speed_sel = 2'd1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          brk_req = 1'b0;
  logic          in_ready, pull_low, done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pw_sym_tx #(.BASE_CYC(BASE), .DATA_W(DW)) i_pw_sym_tx (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .brk_req(brk_req),
    .pull_low(pull_low), .done(done)
  );

  function automatic int exp_bt(logic [1:0] s);
    case (s)
      2'd0:    return BASE * 2;
      2'd1:    return BASE;
      2'd2:    return BASE / 2;
      default: return BASE / 4;
    endcase
  endfunction

  function automatic int exp_low(int bt, logic b);
    real f;
    f = b ? 0.304 : 0.696;
    return $rtoi(bt * f + 0.5);
  endfunction

  function automatic int exp_brk(int bt);
    return $rtoi($ceil(bt * 1.391));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [DW-1:0] d, input logic [1:0] s, input bit disturb);
    int bt;
    int bad_rdy;
    int done_at;
    bt = exp_bt(s);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; speed_sel = s;
    @(negedge clk);
    in_valid = 1'b0;
    bad_rdy = 0; done_at = -1;
    for (int b = 0; b < DW; b++) begin
      int lowc = 0;
      int bad  = 0;
      int el   = exp_low(bt, d[b]);
      for (int c = 0; c < bt; c++) begin
        if (pull_low !== (c < el)) bad++;
        if (pull_low) lowc++;
        if (in_ready) bad_rdy++;
        if (done) done_at = b * bt + c;
        if (disturb) begin
          speed_sel = 2'($urandom);
          in_data   = DW'($urandom);
          in_valid  = 1'($urandom);
          brk_req   = (b >= 1 && b < DW - 1) ? 1'($urandom) : 1'b0;
        end
        @(negedge clk);
      end
      if (d[b]) check(bad == 0, disturb ? "R2/R4/R9/R8 one slot" : "R2/R4 one slot", lowc, el);
      else      check(bad == 0, disturb ? "R3/R4/R9/R8 zero slot" : "R3/R4 zero slot", lowc, el);
    end
    in_valid = 1'b0; brk_req = 1'b0;
    check(bad_rdy == 0, "R5 ready low while busy", bad_rdy, 0);
    check(done_at == DW * bt - 1, "R6/R1 done position", done_at, DW * bt - 1);
    check(in_ready && !pull_low, "R5/R11 idle after byte", {in_ready, pull_low}, 2);
  endtask

  task automatic run_break(input logic [1:0] s, input bit with_valid);
    int bt, bl, bad, done_at;
    bt = exp_bt(s); bl = exp_brk(bt);
    while (!in_ready) @(negedge clk);
    brk_req = 1'b1; speed_sel = s;
    if (with_valid) begin
      in_valid = 1'b1; in_data = 8'hA5;
      #0;
      check(!in_ready, "R8 break wins over valid", in_ready, 0);
    end
    @(negedge clk);
    brk_req = 1'b0; in_valid = 1'b0;
    bad = 0; done_at = -1;
    for (int c = 0; c < bl + bt; c++) begin
      if (pull_low !== (c < bl)) bad++;
      if (done) done_at = c;
      @(negedge clk);
    end
    check(bad == 0, "R7 break waveform", bad, 0);
    check(done_at == bl + bt - 1, "R6/R7 break done position", done_at, bl + bt - 1);
    bad = 0;
    for (int c = 0; c < 2 * bt; c++) begin
      if (pull_low || !in_ready) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8/R11 quiet after break", bad, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    #1;
    check(!pull_low && !done && in_ready, "R10 in reset", {pull_low, done, in_ready}, 1);
    #20; @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!pull_low && !done && in_ready, "R10 after reset", {pull_low, done, in_ready}, 1);
    send_byte(8'h01, 2'd3, 1'b0);
    send_byte(8'hFE, 2'd1, 1'b0);
    send_byte(8'hFF, 2'd0, 1'b0);
    send_byte(8'h00, 2'd2, 1'b0);
    run_break(2'd1, 1'b0);
    run_break(2'd3, 1'b1);
    run_break(2'd0, 1'b0);
    for (int i = 0; i < 10; i++)
      send_byte(DW'($urandom), 2'($urandom), 1'($urandom));
    send_byte(8'h5A, 2'd2, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule